// File: doc/BRIEF.md
# Calendar Alarm Comparator

This block watches the running calendar of a real-time clock and raises an alarm when the calendar reaches a programmed minute. The calendar counters are outside the block. They arrive as BCD inputs for minute, hour, day of month and weekday. A host programs four alarm bytes, one per field. Bit 7 of any alarm byte takes that field out of the comparison, so an alarm can be set for every day at a given time, every hour at a given minute, and so on.

When every field that takes part agrees with the calendar, the block sets a sticky alarm flag. The flag is set only on the clock edge where the agreement begins. If the host has also set the alarm interrupt enable, an active-low level interrupt is driven for as long as both the flag and the enable are set. Seconds are never compared, so the resolution is one minute.

The host reads the flag and the enable from a control byte. It clears the flag by writing that byte with the flag bit at zero.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset the flag is 0 and `irq_n` is 1. The control byte at address 0x1 reads 0x00. Each of the four alarm bytes at 0x9 (minute), 0xA (hour), 0xB (day of month) and 0xC (weekday) reads 0x80, which means disabled.
- R2: Each alarm byte reads back exactly the 8 bits last written to it. The control byte reads the flag at bit 3 and the interrupt enable at bit 1, with all other bits 0. Writing the control byte sets the enable to bit 1 of the written data.
- R3: A field that takes part is compared with the calendar through a mask: 0x7F for minute, 0x3F for hour and day, 0x07 for weekday. The alarm matches when every field that takes part agrees and at least one field takes part.
- R4: An alarm byte with bit 7 set is left out of the comparison, whatever the calendar value of that field.
- R5: With all four alarm bytes disabled the flag is never set.
- R6: The flag is set on the first clock edge at which the match is true. If the flag is cleared while the match persists, it is not set again. It is set again only after the match has gone false and then true once more.
- R7: Writing the control byte with bit 3 at 0 clears the flag on that edge. Writing it with bit 3 at 1 leaves the flag unchanged.
- R8: If a new match begins on the same edge as a clearing write, the flag ends up set.
- R9: `irq_n` is 0 exactly while the flag and the enable are both 1. It stays low until one of them is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_min | input | 7 | Current minute, BCD |
| cur_hour | input | 6 | Current hour, BCD |
| cur_mday | input | 6 | Current day of month, BCD |
| cur_wday | input | 3 | Current weekday |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 4 | Host write address |
| wr_data | input | 8 | Host write data |
| rd_addr | input | 4 | Host read address |
| rd_data | output | 8 | Host read data, combinational |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_n | output | 1 | Active-low alarm interrupt |

## Verification
If the stored previous-match state is wrong, the fault appears on `alarm_flag` one edge after a calendar change. A stuck state shows as a missed alarm, and a cleared state shows as a second set within the same matching minute. If an alarm byte or its disable bit is corrupted, the fault is visible at once through `rd_data`, and on the next edge as a wrong flag. If the enable is wrong, `irq_n` disagrees with the flag in the same cycle. A random calendar walk is checked every cycle against a bench model, so any of these faults is caught within one cycle of the stimulus that exposes it.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int NFIELD   = 4;
  localparam int FLAG_BIT = 3;
  localparam int AIE_BIT  = 1;
  localparam int OFF_BIT  = 7;

  typedef logic [7:0] byte_t;

  // Compare mask of each field: 0 minute, 1 hour, 2 day of month, 3 weekday
  function automatic byte_t field_mask(input int idx);
    case (idx)
      0:       return 8'h7F;
      1, 2:    return 8'h3F;
      default: return 8'h07;
    endcase
  endfunction

  // A field agrees when it is switched off or its masked value equals the calendar
  function automatic logic field_hit(input byte_t alm, input byte_t cur, input byte_t msk);
    return alm[OFF_BIT] | (((alm ^ cur) & msk) == 8'h00);
  endfunction
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
  import rtc_alarm_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CTRL_ADDR = 1,
  parameter int ALM_BASE  = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [7:0]              wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic                    flag,
  output logic [NFIELD-1:0][7:0]  alm,
  output logic                    aie,
  output logic                    clr_req,
  output logic [7:0]              rd_data
);
  logic ctrl_wr;
  assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
  assign clr_req = ctrl_wr && !wr_data[FLAG_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       aie <= 1'b0;
    else if (ctrl_wr) aie <= wr_data[AIE_BIT];
  end

  for (genvar g = 0; g < NFIELD; g++) begin : g_alm
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        alm[g] <= 8'h80;
      else if (wr_en && wr_addr == ADDR_W'(ALM_BASE + g))
        alm[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_addr == ADDR_W'(CTRL_ADDR)) begin
      rd_data[FLAG_BIT] = flag;
      rd_data[AIE_BIT]  = aie;
    end
    for (int k = 0; k < NFIELD; k++)
      if (rd_addr == ADDR_W'(ALM_BASE + k)) rd_data = alm[k];
  end
endmodule

// File: rtl/alarm_compare.sv
module alarm_compare
  import rtc_alarm_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NFIELD-1:0][7:0]  alm,
  input  logic [NFIELD-1:0][7:0]  cur,
  output logic                    hit,
  output logic                    any_on
);
  logic [NFIELD-1:0] fhit;
  logic [NFIELD-1:0] fon;

  for (genvar g = 0; g < NFIELD; g++) begin : g_fld
    assign fhit[g] = field_hit(alm[g], cur[g], field_mask(g));
    assign fon[g]  = ~alm[g][OFF_BIT];
  end

  assign any_on = |fon;
  assign hit    = any_on && (&fhit);

  // R5
  all_off_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alm[0][7] && alm[1][7] && alm[2][7] && alm[3][7]) |-> !hit);
endmodule

// File: rtl/alarm_flag.sv
module alarm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr_req,
  input  logic aie,
  output logic flag,
  output logic irq_n
);
  logic hit_prev;
  logic hit_rise;

  assign hit_rise = hit && !hit_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_prev <= 1'b0;
      flag     <= 1'b0;
    end else begin
      hit_prev <= hit;
      if (hit_rise)     flag <= 1'b1;
      else if (clr_req) flag <= 1'b0;
    end
  end

  assign irq_n = !(flag && aie);

  // R8
  rise_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_rise |=> flag);
  // R6
  flag_needs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !hit_rise) |=> !flag);
  // R7
  clear_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !hit_rise) |=> !flag);
  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_req) |=> flag);
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CTRL_ADDR = 1,
  parameter int ALM_BASE  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6:0]        cur_min,
  input  logic [5:0]        cur_hour,
  input  logic [5:0]        cur_mday,
  input  logic [2:0]        cur_wday,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              alarm_flag,
  output logic              irq_n
);
  logic [NFIELD-1:0][7:0] alm;
  logic [NFIELD-1:0][7:0] cur;
  logic aie, clr_req, hit, any_on;

  assign cur[0] = {1'b0, cur_min};
  assign cur[1] = {2'b0, cur_hour};
  assign cur[2] = {2'b0, cur_mday};
  assign cur[3] = {5'b0, cur_wday};

  alarm_regs #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .ALM_BASE(ALM_BASE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .flag(alarm_flag), .alm(alm), .aie(aie), .clr_req(clr_req),
    .rd_data(rd_data)
  );

  alarm_compare u_cmp (
    .clk(clk), .rst_n(rst_n), .alm(alm), .cur(cur), .hit(hit), .any_on(any_on)
  );

  alarm_flag u_flag (
    .clk(clk), .rst_n(rst_n), .hit(hit), .clr_req(clr_req), .aie(aie),
    .flag(alarm_flag), .irq_n(irq_n)
  );

  // R9
  irq_implies_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> alarm_flag);
endmodule

// File: tb/rtc_alarm_match_test.sv
`timescale 1ns/100ps
module rtc_alarm_match_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] cur_min = '0;
  logic [5:0] cur_hour = '0;
  logic [5:0] cur_mday = 6'h01;
  logic [2:0] cur_wday = '0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic alarm_flag, irq_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] m_alm [4];
  logic m_flag = 1'b0, m_prev = 1'b0, m_aie = 1'b0;

  always #2.5 clk = ~clk;

  rtc_alarm_match uut (
    .clk(clk), .rst_n(rst_n), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_mday(cur_mday), .cur_wday(cur_wday), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .alarm_flag(alarm_flag), .irq_n(irq_n)
  );

  // Bench restatement of R3/R4: count fields that take part and fields that agree
  function automatic bit b_hit();
    int used = 0;
    int ok = 0;
    logic [7:0] cv [4];
    logic [7:0] mk [4];
    cv[0] = {1'b0, cur_min};  mk[0] = 8'h7F;
    cv[1] = {2'b0, cur_hour}; mk[1] = 8'h3F;
    cv[2] = {2'b0, cur_mday}; mk[2] = 8'h3F;
    cv[3] = {5'b0, cur_wday}; mk[3] = 8'h07;
    for (int i = 0; i < 4; i++) begin
      if (m_alm[i][7] == 1'b0) begin
        used++;
        if ((m_alm[i] & mk[i]) == (cv[i] & mk[i])) ok++;
      end
    end
    return (used > 0) && (ok == used);
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h at %0t", req, got, exp, $time);
    end
  endtask

  // One clock: update the model from the inputs present at the edge, then return at the next negedge
  task automatic cyc();
    bit h;
    h = b_hit();
    if (wr_en && wr_addr == 4'h1) begin
      if (h && !m_prev) m_flag = 1'b1;
      else if (!wr_data[3]) m_flag = 1'b0;
      m_aie = wr_data[1];
    end else if (h && !m_prev) m_flag = 1'b1;
    m_prev = h;
    if (wr_en && wr_addr >= 4'h9 && wr_addr <= 4'hC) m_alm[wr_addr - 4'h9] = wr_data;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic chk_model(input string req);
    chk(req, {7'b0, alarm_flag}, {7'b0, m_flag});
    chk(req, {7'b0, irq_n}, {7'b0, !(m_flag && m_aie)});
  endtask

  function automatic logic [7:0] pick_bcd(input int f);
    int r = $urandom % 3;
    case (f)
      0: return (r == 0) ? 8'h00 : (r == 1) ? 8'h15 : 8'h59;
      1: return (r == 0) ? 8'h00 : (r == 1) ? 8'h12 : 8'h23;
      2: return (r == 0) ? 8'h01 : (r == 1) ? 8'h15 : 8'h31;
      default: return (r == 0) ? 8'h00 : (r == 1) ? 8'h03 : 8'h06;
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) m_alm[i] = 8'h80;
    #12;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", {7'b0, alarm_flag}, 8'h00);
    chk("R1", {7'b0, irq_n}, 8'h01);
    rd(4'h1, d); chk("R1", d, 8'h00);
    for (int a = 9; a <= 12; a++) begin rd(4'(a), d); chk("R1", d, 8'h80); end

    // R2 readback, R3 minute-only alarm
    wr(4'h9, 8'h30);
    wr(4'h1, 8'h02);
    rd(4'h9, d); chk("R2", d, 8'h30);
    rd(4'h1, d); chk("R2", d, 8'h02);
    cur_min = 7'h30; cyc();
    chk("R3", {7'b0, alarm_flag}, 8'h01);
    chk("R9", {7'b0, irq_n}, 8'h00);
    rd(4'h1, d); chk("R2", d, 8'h0A);

    // R7 clear while match persists; R6 no re-set
    wr(4'h1, 8'h02);
    chk("R7", {7'b0, alarm_flag}, 8'h00);
    chk("R9", {7'b0, irq_n}, 8'h01);
    cyc(); cyc();
    chk("R6", {7'b0, alarm_flag}, 8'h00);

    // R6 re-arm after the match drops
    cur_min = 7'h31; cyc();
    cur_min = 7'h30; cyc();
    chk("R6", {7'b0, alarm_flag}, 8'h01);
    wr(4'h1, 8'h0A);
    chk("R7", {7'b0, alarm_flag}, 8'h01);

    // R9 enable off keeps irq high with the flag set
    wr(4'h1, 8'h08);
    chk("R9", {7'b0, irq_n}, 8'h01);
    chk("R9", {7'b0, alarm_flag}, 8'h01);
    wr(4'h1, 8'h02);

    // R4 hour field joins the comparison
    wr(4'hA, 8'h12);
    cur_hour = 6'h05; cur_min = 7'h31; cyc();
    cur_min = 7'h30; cyc();
    chk("R4", {7'b0, alarm_flag}, 8'h00);
    cur_hour = 6'h12; cyc();
    chk("R3", {7'b0, alarm_flag}, 8'h01);
    // R4 a disabled field is ignored: weekday and day stay off while they vary
    cur_wday = 3'd5; cur_mday = 6'h27; cyc();
    chk("R4", {7'b0, alarm_flag}, 8'h01);
    wr(4'h1, 8'h02);

    // R8 match begins on the clearing edge
    cur_min = 7'h31; cyc();
    cur_min = 7'h30;
    wr(4'h1, 8'h02);
    chk("R8", {7'b0, alarm_flag}, 8'h01);
    wr(4'h1, 8'h02);

    // R5 all fields disabled
    wr(4'h9, 8'hB0); wr(4'hA, 8'h92);
    for (int i = 0; i < 6; i++) begin
      cur_min = 7'(i * 3); cyc();
      cur_min = 7'h30; cyc();
    end
    chk("R5", {7'b0, alarm_flag}, 8'h00);
    rd(4'h9, d); chk("R2", d, 8'hB0);

    // Random walk, R3 R4 R6 R7 R8 R9 against the model
    for (int n = 0; n < 3000; n++) begin
      if ($urandom % 8 == 0) begin
        int f = $urandom % 4;
        logic [7:0] v = pick_bcd(f);
        if ($urandom % 3 == 0) v[7] = 1'b1;
        if ($urandom % 5 == 0) v[6] = 1'b1;
        wr_en = 1'b1; wr_addr = 4'(9 + f); wr_data = v;
      end else if ($urandom % 6 == 0) begin
        wr_en = 1'b1; wr_addr = 4'h1;
        wr_data = {4'b0, 1'($urandom % 2), 1'b0, 1'($urandom % 4 != 0), 1'b0};
      end
      cur_min  = 7'(pick_bcd(0));
      cur_hour = 6'(pick_bcd(1));
      cur_mday = 6'(pick_bcd(2));
      cur_wday = 3'(pick_bcd(3));
      cyc();
      chk_model("R6");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule